// File: doc/BRIEF.md
# Multi-Cycle 16-bit RISC Core

This block is a compact processor core built around a 16-bit data word and a sixteen-entry register file. A finite-state controller walks each instruction through a short series of states. The first state presents the program counter to memory. The next captures the instruction word and decodes it. An execute step uses the single shared ALU. Memory access or register write-back follows only where the instruction needs it. The core connects to one external word-addressed memory. That memory returns read data one clock after it sees an address.

A third read port on the register file is reserved for observation. A 4-bit select input picks a register, and a registered 16-bit output shows its value. This lets a board or a testbench inspect architectural state without disturbing execution. A HALT instruction parks the core until the next reset.

Instruction layout: opcode in bits [15:12], destination/first operand `rd` in [11:8], source `rs` in [7:4], and a 4-bit signed immediate in [3:0]. The jump-and-link target uses bits [11:0] as an unsigned absolute address.

Top module: `rc16_core`

## Requirements
- R1: Synchronous active-high reset clears the program counter, instruction register and all sixteen registers, and puts the controller in its fetch state. While reset is held, `mem_addr` is 0, `mem_we` is 0 and `halted` is 0.
- R2: A fetch drives `mem_addr` with the PC and increments the PC by one. The word returned on `mem_rdata` in the next cycle becomes the instruction.
- R3: Opcodes 1 (add), 2 (subtract), 3 (AND) and 4 (OR) compute `rd op rs` and write the result into `rd`. Subtraction is two's complement.
- R4: Opcode 5 adds the sign-extended 4-bit immediate to `rd` and writes the sum back into `rd`.
- R5: Opcode 6 loads `rd` from word address `rs + sext(imm)`. Opcode 7 stores `rd` to that address, with `mem_we` high for exactly one cycle. Only the low 13 address bits are driven.
- R6: Opcode 8 branches when `rd == rs`. The target is the address of the following instruction plus the sign-extended immediate. When not taken, execution falls through.
- R7: Opcode 9 branches to the same kind of target when `rd < rs` as signed values. The comparison stays correct when `rd - rs` overflows.
- R8: Opcode 10 writes the address of the following instruction into register 15 and jumps to the zero-extended 12-bit field. Opcode 11 jumps to the address held in `rd`.
- R9: Opcode 0 halts the core. From then until reset, `halted` stays 1, no further fetch address is issued and `mem_we` stays 0.
- R10: Opcodes 12 to 15 change no register and no memory word. Execution continues with the next instruction.
- R11: `dbg_value` shows the register chosen by `dbg_sel` one clock after the select is applied. This port is independent of the operand ports.
- R12: Instruction latency in clocks is as follows. Add, subtract, AND, OR and add-immediate take 5. A load takes 6. A store takes 5. Branches, jumps, no-ops and HALT take 4, with HALT measured up to entry into the halted state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 13 | Word address to the external memory |
| mem_we | output | 1 | Write strobe, one cycle per store |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| dbg_sel | input | 4 | Register chosen for observation |
| dbg_value | output | 16 | Registered contents of the chosen register |
| halted | output | 1 | High once a HALT has executed |

## Verification
Some properties are checked on every clock by assertions. Each store strobe lasts one cycle. The instruction capture always follows a fetch, and every fetch advances the PC by one. The halted state is never left without reset and never writes memory. A jump-and-link lands on its encoded field. The subtract zero flag agrees with operand equality. Only the bench's program can show that register results, effective addresses, signed comparisons across overflow and link addresses are architecturally right, together with the per-class cycle totals and the debug port's one-clock latency. It runs a program that covers every opcode class, then compares each register and the stored memory word with values worked out by hand.

// File: rtl/rc16_pkg.sv
package rc16_pkg;

  typedef enum logic [3:0] {
    OP_HALT = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_ADDI = 4'd5,
    OP_LW   = 4'd6,
    OP_SW   = 4'd7,
    OP_BEQ  = 4'd8,
    OP_BLT  = 4'd9,
    OP_JAL  = 4'd10,
    OP_JR   = 4'd11
  } opcode_e;

  typedef enum logic [2:0] {
    S_FETCH, S_LOADIR, S_DECODE, S_EXEC, S_MEM, S_MEMRD, S_WB, S_HALT
  } state_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} aluop_e;
  typedef enum logic [1:0] {A_REG, A_OPB, A_PC} asel_e;
  typedef enum logic [1:0] {W_ALU, W_MEM, W_LINK} wsrc_e;
  typedef enum logic [1:0] {P_TGT, P_ABS, P_REG} pcsrc_e;

  typedef struct packed {
    logic   ir_ld;
    logic   pc_inc;
    logic   opnd_ld;
    logic   aluo_ld;
    aluop_e alu_op;
    asel_e  a_sel;
    logic   b_imm;
    logic   rf_we;
    wsrc_e  w_src;
    logic   pc_ld;
    pcsrc_e pc_src;
    logic   addr_alu;
    logic   mem_we;
  } ctrl_t;

endpackage

// File: rtl/rc16_alu.sv
module rc16_alu
  import rc16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  aluop_e       op,
  output logic [W-1:0] y,
  output logic         zf,
  output logic         nf,
  output logic         vf
);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      default: y = a | b;
    endcase
    zf = (y == '0);
    nf = y[W-1];
    vf = (op == ALU_SUB) ? ((a[W-1] != b[W-1]) && (y[W-1] != a[W-1]))
                         : ((op == ALU_ADD) && (a[W-1] == b[W-1]) && (y[W-1] != a[W-1]));
  end

  // R6: after a subtract the zero flag must track operand equality
  always_comb begin
    if (op == ALU_SUB) begin
      assert_sub_zero_R6: assert (zf == (a == b));
    end
  end

endmodule

// File: rtl/rc16_regfile.sv
module rc16_regfile #(
  parameter int W = 16,
  parameter int N = 16,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  input  logic [AW-1:0] rdbg,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  output logic [W-1:0]  dbg
);

  logic [W-1:0] cells [N];

  generate
    for (genvar g = 0; g < N; g++) begin : g_cell
      always_ff @(posedge clk) begin
        if (rst)                            cells[g] <= '0;
        else if (we && (wa == AW'(g)))      cells[g] <= wd;
      end
    end
  endgenerate

  assign rd1 = cells[ra1];
  assign rd2 = cells[ra2];

  always_ff @(posedge clk) begin
    if (rst) dbg <= '0;
    else     dbg <= cells[rdbg];
  end

endmodule

// File: rtl/rc16_ctrl.sv
module rc16_ctrl
  import rc16_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] opcode,
  input  logic       zf,
  input  logic       nf,
  input  logic       vf,
  output state_e     st,
  output ctrl_t      c
);

  state_e nx;
  logic   take;

  always_comb begin
    unique case (opcode)
      OP_BEQ:  take = zf;
      OP_BLT:  take = nf ^ vf;
      default: take = 1'b0;
    endcase
  end

  always_comb begin
    c  = '0;
    nx = st;
    unique case (st)
      S_FETCH: begin
        c.pc_inc = 1'b1;
        nx       = S_LOADIR;
      end
      S_LOADIR: begin
        c.ir_ld = 1'b1;
        nx      = S_DECODE;
      end
      S_DECODE: begin
        c.opnd_ld = 1'b1;
        c.aluo_ld = 1'b1;
        c.a_sel   = A_PC;
        c.b_imm   = 1'b1;
        c.alu_op  = ALU_ADD;
        nx        = S_EXEC;
      end
      S_EXEC: begin
        nx = S_FETCH;
        unique case (opcode)
          OP_ADD, OP_SUB, OP_AND, OP_OR: begin
            c.aluo_ld = 1'b1;
            c.alu_op  = aluop_e'(opcode[1:0] - 2'd1);
            nx        = S_WB;
          end
          OP_ADDI: begin
            c.aluo_ld = 1'b1;
            c.b_imm   = 1'b1;
            nx        = S_WB;
          end
          OP_LW, OP_SW: begin
            c.aluo_ld = 1'b1;
            c.a_sel   = A_OPB;
            c.b_imm   = 1'b1;
            nx        = S_MEM;
          end
          OP_BEQ, OP_BLT: begin
            c.alu_op = ALU_SUB;
            c.pc_ld  = take;
            c.pc_src = P_TGT;
          end
          OP_JAL: begin
            c.rf_we  = 1'b1;
            c.w_src  = W_LINK;
            c.pc_ld  = 1'b1;
            c.pc_src = P_ABS;
          end
          OP_JR: begin
            c.pc_ld  = 1'b1;
            c.pc_src = P_REG;
          end
          OP_HALT: nx = S_HALT;
          default: nx = S_FETCH;
        endcase
      end
      S_MEM: begin
        c.addr_alu = 1'b1;
        if (opcode == OP_SW) begin
          c.mem_we = 1'b1;
          nx       = S_FETCH;
        end else begin
          nx = S_MEMRD;
        end
      end
      S_MEMRD: begin
        c.rf_we = 1'b1;
        c.w_src = W_MEM;
        nx      = S_FETCH;
      end
      S_WB: begin
        c.rf_we = 1'b1;
        c.w_src = W_ALU;
        nx      = S_FETCH;
      end
      default: nx = S_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= S_FETCH;
    else     st <= nx;
  end

  // R5: a store strobe never lasts more than one cycle
  assert_we_single_R5: assert property (@(posedge clk) disable iff (rst)
    c.mem_we |=> !c.mem_we);

  // R9: the halted state is left only through reset and never writes
  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (st == S_HALT) |=> (st == S_HALT) && !c.mem_we);

  // R2: instruction capture is always preceded by a fetch
  assert_capture_after_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    (st == S_LOADIR) |-> ($past(st) == S_FETCH));

endmodule

// File: rtl/rc16_core.sv
module rc16_core
  import rc16_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 13,
  parameter int REG_N  = 16
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [3:0]        dbg_sel,
  output logic [DATA_W-1:0] dbg_value,
  output logic              halted
);

  localparam int RAW   = $clog2(REG_N);
  localparam int IMM_W = 4;
  localparam int ABS_W = 12;

  state_e             st;
  ctrl_t              c;
  logic [ADDR_W-1:0]  pc;
  logic [DATA_W-1:0]  ir, opa, opb, aluo;
  logic [DATA_W-1:0]  rf_rd1, rf_rd2, rf_wd, alu_a, alu_b, alu_y, imm_sx;
  logic [RAW-1:0]     rf_wa;
  logic               zf, nf, vf;

  assign imm_sx = {{(DATA_W-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]};

  rc16_ctrl u_ctrl (
    .clk(clk), .rst(rst), .opcode(ir[15:12]),
    .zf(zf), .nf(nf), .vf(vf), .st(st), .c(c)
  );

  rc16_regfile #(.W(DATA_W), .N(REG_N)) u_rf (
    .clk(clk), .rst(rst),
    .ra1(ir[8 +: RAW]), .ra2(ir[4 +: RAW]), .rdbg(dbg_sel[RAW-1:0]),
    .we(c.rf_we), .wa(rf_wa), .wd(rf_wd),
    .rd1(rf_rd1), .rd2(rf_rd2), .dbg(dbg_value)
  );

  always_comb begin
    unique case (c.a_sel)
      A_OPB:   alu_a = opb;
      A_PC:    alu_a = {{(DATA_W-ADDR_W){1'b0}}, pc};
      default: alu_a = opa;
    endcase
    alu_b = c.b_imm ? imm_sx : opb;
  end

  rc16_alu #(.W(DATA_W)) u_alu (
    .a(alu_a), .b(alu_b), .op(c.alu_op),
    .y(alu_y), .zf(zf), .nf(nf), .vf(vf)
  );

  always_comb begin
    unique case (c.w_src)
      W_MEM:   rf_wd = mem_rdata;
      W_LINK:  rf_wd = {{(DATA_W-ADDR_W){1'b0}}, pc};
      default: rf_wd = aluo;
    endcase
    rf_wa = (c.w_src == W_LINK) ? RAW'(REG_N-1) : ir[8 +: RAW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc   <= '0;
      ir   <= '0;
      opa  <= '0;
      opb  <= '0;
      aluo <= '0;
    end else begin
      if (c.ir_ld)   ir <= mem_rdata;
      if (c.opnd_ld) begin
        opa <= rf_rd1;
        opb <= rf_rd2;
      end
      if (c.aluo_ld) aluo <= alu_y;
      if (c.pc_inc) begin
        pc <= pc + 1'b1;
      end else if (c.pc_ld) begin
        unique case (c.pc_src)
          P_ABS:   pc <= {{(ADDR_W-ABS_W){1'b0}}, ir[ABS_W-1:0]};
          P_REG:   pc <= opa[ADDR_W-1:0];
          default: pc <= aluo[ADDR_W-1:0];
        endcase
      end
    end
  end

  assign mem_addr  = c.addr_alu ? aluo[ADDR_W-1:0] : pc;
  assign mem_we    = c.mem_we;
  assign mem_wdata = opa;
  assign halted    = (st == S_HALT);

  // R2: every fetch advances the PC by exactly one
  assert_fetch_step_R2: assert property (@(posedge clk) disable iff (rst)
    (st == S_FETCH) |=> (pc == $past(pc) + 1'b1));

  // R8: a jump-and-link lands on its encoded 12-bit field
  assert_jal_target_R8: assert property (@(posedge clk) disable iff (rst)
    (st == S_EXEC && ir[15:12] == OP_JAL) |=> (pc == {{(ADDR_W-ABS_W){1'b0}}, $past(ir[ABS_W-1:0])}));

  // R1: the cycle after a reset edge sees a cleared PC in the fetch state
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (pc == '0 && st == S_FETCH));

endmodule

// File: tb/tb_rc16_core.sv
`timescale 1ns/1ps
module tb_rc16_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic [3:0]  dbg_sel = '0;
  logic [15:0] dbg_value;
  logic        halted;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  rc16_core dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dbg_sel(dbg_sel), .dbg_value(dbg_value), .halted(halted)
  );

  // program (stimulus) table
  localparam logic [15:0] PROG [29] = '{
    16'h5107, 16'h520D, 16'h1310, 16'h2320, 16'h5406, 16'h5505, 16'h3540, 16'h4410,
    16'h7317, 16'h6717, 16'h8732, 16'h7FFF, 16'h8000, 16'h9211, 16'h5801, 16'h9123,
    16'h6A14, 16'h6B15, 16'h9BA1, 16'h5801, 16'h9AB1, 16'h5C01, 16'hA01A, 16'h5901,
    16'h0000, 16'h5801, 16'h8121, 16'hC123, 16'hBF00
  };

  // expected register contents after HALT
  localparam logic [15:0] EXP_REG [16] = '{
    16'h0000, 16'h0007, 16'hFFFD, 16'h000A, 16'h0007, 16'h0004, 16'h0000, 16'h000A,
    16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'h0001, 16'h0000, 16'h0000, 16'h0017
  };

  logic [15:0] mem [64];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[5:0]];
  end

  function automatic string reg_tag(int r);
    case (r)
      1:       return "R10";
      2:       return "R4";
      3, 4, 5: return "R3";
      7:       return "R5";
      8:       return "R6";
      10, 11:  return "R5";
      12:      return "R7";
      9, 15:   return "R8";
      default: return "R1";
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL R9: watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int cyc  = 0;
    int wr   = 0;
    logic [12:0] addr_hold;
    for (int i = 0; i < 64; i++) mem[i] = (i < 29) ? PROG[i] : 16'h0000;

    // R1: state while reset is held
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 addr in reset", {3'b0, mem_addr}, 16'h0000);
    check("R1 we in reset", {15'b0, mem_we}, 16'h0000);
    check("R1 halted in reset", {15'b0, halted}, 16'h0000);
    check("R1 dbg in reset", dbg_value, 16'h0000);
    dbg_sel = 4'd1;
    rst     = 1'b0;

    while (!halted && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (mem_we) wr++;
      if (cyc == 1) check("R1 r1 cleared", dbg_value, 16'h0000);
      if (cyc == 1) check("R2 fetch addr advanced", {3'b0, mem_addr}, 16'h0001);
    end
    if (cyc >= 5000) begin
      fails++;
      $display("FAIL R9: halt not reached, actual %0d expected 113", cyc);
    end

    check("R12 cycles to halt", 16'(cyc), 16'd113);
    check("R5 store strobes", 16'(wr), 16'd1);
    check("R5 stored word", mem[14], 16'h000A);

    // R11: debug port walk, one clock per select
    for (int r = 0; r < 16; r++) begin
      dbg_sel = 4'(r);
      @(negedge clk);
      check(reg_tag(r), dbg_value, EXP_REG[r]);
    end

    // R9: nothing moves once halted
    addr_hold = mem_addr;
    wr = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (mem_we) wr++;
      if (!halted || mem_addr != addr_hold) wr += 100;
    end
    check("R9 quiet after halt", 16'(wr), 16'd0);

    // R1: second reset
    rst = 1'b1;
    dbg_sel = 4'd15;
    @(negedge clk);
    check("R1 halted cleared", {15'b0, halted}, 16'h0000);
    check("R1 addr cleared", {3'b0, mem_addr}, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    check("R1 r15 cleared", dbg_value, 16'h0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule